// File: doc/BRIEF.md
# Legacy Keyboard Emulation Controller

This block is the control and status core that lets a USB host controller stand in for a legacy keyboard/mouse controller. It holds one 32-bit control word at offset 100h, snoops I/O writes to the keyboard data port (60h) and command port (64h), and watches the IRQ1 and IRQ12 lines of a real keyboard controller. From these, plus the output-full and auxiliary-output-full flags supplied by a companion status register, it drives IRQ1 and IRQ12 to the system and raises an emulation interrupt that invokes emulation software.

The port snooper recognises the gate-A20 command (D1h written to port 64h). While that sequence is armed, a data-port write whose bit 1 disagrees with the recorded A20 level traps to software. Rising edges on the external IRQ lines are kept as sticky flags that software clears by writing 1. The system IRQ is steered to IRQ1 or IRQ12 by the auxiliary-output-full flag.

Top module: `kbd_emul_ctrl`

## Requirements
- R1: After reset every control bit reads 0 and irq1_out, irq12_out and emu_irq are 0.
- R2: Bits 31:9 read 0 and ignore writes; bit 1 (emulation interrupt) and bit 5 (gate-A20 armed) cannot be written by software. Bits 0 (emulation enable), 2 (character pending), 3 (IRQ enable), 4 (external IRQ enable) and 8 (A20 level) are ordinary read/write bits.
- R3: A rising edge on kbc_irq1 (kbc_irq12) sets bit 6 (bit 7); the flag reads 1 two clock edges after the input rises. A level that stays high sets the flag only once.
- R4: Writing 1 to bit 6 or bit 7 clears that flag; writing 0 leaves it unchanged.
- R5: With emulation enabled, a write of D1h to port 64h sets bit 5, and a write of any other value to port 64h clears it. Bit 5 changes two clock edges after the write is presented.
- R6: While bit 0 is 0, writes to ports 60h and 64h have no effect on bit 5 or on the A20 trap.
- R7: While bit 3 is 1 and obf is 1, irq1_out is 1 when aux_obf is 0 and irq12_out is 1 when aux_obf is 1. Otherwise both are 0, and they are never 1 together.
- R8: While bit 2 is 1 and obf is 0, emu_irq is 1.
- R9: While bit 4 is 1 and bit 6 or bit 7 is set, emu_irq is 1 whatever bit 0 holds.
- R10: While bit 5 is 1, a port 60h write whose data bit 1 differs from bit 8 latches an A20 trap that holds emu_irq at 1. A matching write does not. The trap clears on any control-word write or any port 64h write.
- R11: Bit 1 reads the same value as emu_irq in the same cycle.
- R12: Only offset 100h reaches the control word. Writes to other offsets are ignored, and reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| io_wr | input | 1 | Snooped I/O write strobe |
| io_port | input | 16 | Snooped I/O port number |
| io_data | input | 8 | Snooped I/O write data |
| kbc_irq1 | input | 1 | IRQ1 from the keyboard controller |
| kbc_irq12 | input | 1 | IRQ12 from the keyboard controller |
| obf | input | 1 | Output-full flag from the status register |
| aux_obf | input | 1 | Auxiliary-output-full flag from the status register |
| irq1_out | output | 1 | IRQ1 to the system |
| irq12_out | output | 1 | IRQ12 to the system |
| emu_irq | output | 1 | Emulation interrupt |

## Verification
The hardest condition to reach from the ports is the A20 trap. It needs emulation enabled, a D1h command that has passed through the capture stage, and then a data-port write whose bit 1 disagrees with the programmed A20 level, with no control-word or command-port write in between. The bench sets the A20 level first, arms the sequence, and sends matching and then mismatching data writes. It then clears the trap once by a control-word write and once by a command-port write, and repeats the whole run with the opposite A20 level.

// File: rtl/kbe_pkg.sv
package kbe_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned USED_W  = 9;
  // field positions inside the control word
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_EIRQ  = 1;
  localparam int unsigned B_CPEND = 2;
  localparam int unsigned B_IRQEN = 3;
  localparam int unsigned B_XEN   = 4;
  localparam int unsigned B_SEQ   = 5;
  localparam int unsigned B_ACT1  = 6;
  localparam int unsigned B_ACT12 = 7;
  localparam int unsigned B_A20   = 8;
  localparam logic [7:0]  A20_CMD = 8'hD1;

  typedef struct packed {
    logic a20;
    logic act12;
    logic act1;
    logic xen;
    logic irqen;
    logic cpend;
    logic en;
  } ctl_t;

  // system IRQ steering: {irq12, irq1}
  function automatic logic [1:0] f_route(input logic irqen, input logic full,
                                         input logic aux);
    logic [1:0] r;
    r = 2'b00;
    if (irqen && full) r = aux ? 2'b10 : 2'b01;
    return r;
  endfunction

  // emulation interrupt decode
  function automatic logic f_emu(input ctl_t c, input logic full,
                                 input logic trap);
    return (c.cpend && !full) || (c.xen && (c.act1 || c.act12)) || trap;
  endfunction

  // a data-port write disagrees with the recorded A20 level
  function automatic logic f_a20_miss(input logic [7:0] d, input logic lvl);
    return d[1] != lvl;
  endfunction
endpackage

// File: rtl/kbe_edge_det.sv
module kbe_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1, s2;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1[g] <= 1'b0;
        s2[g] <= 1'b0;
      end else begin
        s1[g] <= lvl_in[g];
        s2[g] <= s1[g];
      end
    end
    assign rise[g] = s1[g] & ~s2[g];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]); // R3
  end
endmodule

// File: rtl/kbe_port_snoop.sv
module kbe_port_snoop
  import kbe_pkg::*;
#(
  parameter int unsigned       PORT_W   = 16,
  parameter int unsigned       DATA_W   = 8,
  parameter logic [PORT_W-1:0] DATA_PRT = 16'h0060,
  parameter logic [PORT_W-1:0] CMD_PRT  = 16'h0064
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emu_en,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  input  logic              a20_lvl,
  input  logic              trap_clr,
  output logic              seq_armed,
  output logic              a20_trap,
  output logic              ev_cmd,
  output logic              ev_data
);
  logic              cap_vld;
  logic [PORT_W-1:0] cap_port;
  logic [DATA_W-1:0] cap_data;
  logic              miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_vld  <= 1'b0;
      cap_port <= '0;
      cap_data <= '0;
    end else begin
      cap_vld  <= io_wr & emu_en;
      cap_port <= io_port;
      cap_data <= io_data;
    end
  end

  assign ev_cmd  = cap_vld && (cap_port == CMD_PRT);
  assign ev_data = cap_vld && (cap_port == DATA_PRT);
  assign miss    = ev_data && seq_armed && f_a20_miss(cap_data[7:0], a20_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) seq_armed <= 1'b0;
    else if (ev_cmd) seq_armed <= (cap_data[7:0] == A20_CMD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) a20_trap <= 1'b0;
    else if (ev_cmd || trap_clr) a20_trap <= 1'b0;
    else if (miss) a20_trap <= 1'b1;
  end

  AST_NO_DECODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_en |=> !cap_vld); // R6
  AST_SEQ_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && cap_data[7:0] == A20_CMD) |=> seq_armed); // R5
  AST_SEQ_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && cap_data[7:0] != A20_CMD) |=> !seq_armed); // R5
  AST_TRAP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd || trap_clr) |=> !a20_trap); // R10
endmodule

// File: rtl/kbe_ctrl_regs.sv
module kbe_ctrl_regs
  import kbe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  input  logic [1:0]        rise,
  input  logic              seq_armed,
  input  logic              emu_now,
  output ctl_t              ctl,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (wr_hit) begin
        ctl.en    <= wdata[B_EN];
        ctl.cpend <= wdata[B_CPEND];
        ctl.irqen <= wdata[B_IRQEN];
        ctl.xen   <= wdata[B_XEN];
        ctl.a20   <= wdata[B_A20];
      end
      // an edge in the same cycle as a clear is kept
      if (rise[0]) ctl.act1 <= 1'b1;
      else if (wr_hit && wdata[B_ACT1]) ctl.act1 <= 1'b0;
      if (rise[1]) ctl.act12 <= 1'b1;
      else if (wr_hit && wdata[B_ACT12]) ctl.act12 <= 1'b0;
    end
  end

  always_comb begin
    word          = '0;
    word[B_EN]    = ctl.en;
    word[B_EIRQ]  = emu_now;
    word[B_CPEND] = ctl.cpend;
    word[B_IRQEN] = ctl.irqen;
    word[B_XEN]   = ctl.xen;
    word[B_SEQ]   = seq_armed;
    word[B_ACT1]  = ctl.act1;
    word[B_ACT12] = ctl.act12;
    word[B_A20]   = ctl.a20;
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rise[0] |=> ctl.act1); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wdata[B_ACT12] && !rise[1]) |=> !ctl.act12); // R4
  AST_W0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.act1 && !(wr_hit && wdata[B_ACT1])) |=> ctl.act1); // R4
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word[WORD_W-1:USED_W] == '0); // R2
endmodule

// File: rtl/kbd_emul_ctrl.sv
module kbd_emul_ctrl
  import kbe_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]   CTRL_OFS = 12'h100,
  parameter int unsigned         PORT_W   = 16,
  parameter int unsigned         DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [DATA_W-1:0] io_data,
  input  logic              kbc_irq1,
  input  logic              kbc_irq12,
  input  logic              obf,
  input  logic              aux_obf,
  output logic              irq1_out,
  output logic              irq12_out,
  output logic              emu_irq
);
  localparam int unsigned N_IRQ = 2;

  logic              sel;
  logic              wr_hit;
  logic [N_IRQ-1:0]  rise;
  logic              seq_armed, a20_trap, ev_cmd, ev_data;
  ctl_t              ctl;
  logic [WORD_W-1:0] word;
  logic [1:0]        route;

  assign sel    = (reg_addr == CTRL_OFS);
  assign wr_hit = reg_wr && sel;

  kbe_edge_det #(.N(N_IRQ)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_in({kbc_irq12, kbc_irq1}), .rise(rise)
  );

  kbe_port_snoop #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n), .emu_en(ctl.en), .io_wr(io_wr),
    .io_port(io_port), .io_data(io_data), .a20_lvl(ctl.a20),
    .trap_clr(wr_hit), .seq_armed(seq_armed), .a20_trap(a20_trap),
    .ev_cmd(ev_cmd), .ev_data(ev_data)
  );

  kbe_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(reg_wdata),
    .rise(rise), .seq_armed(seq_armed), .emu_now(emu_irq),
    .ctl(ctl), .word(word)
  );

  assign route     = f_route(ctl.irqen, obf, aux_obf);
  assign irq1_out  = route[0];
  assign irq12_out = route[1];
  assign emu_irq   = f_emu(ctl, obf, a20_trap);
  assign reg_rdata = sel ? word : '0;

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq1_out && irq12_out)); // R7
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq1_out || irq12_out) |-> (obf && ctl.irqen)); // R7
  AST_TRAP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    a20_trap |-> emu_irq); // R10
  AST_XIRQ_ANY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.xen && (ctl.act1 || ctl.act12)) |-> emu_irq); // R9
endmodule

// File: tb/sim_kbd_emul_ctrl.sv
`timescale 1ns/1ps
module sim_kbd_emul_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = 12'h100;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        io_wr = 1'b0;
  logic [15:0] io_port = '0;
  logic [7:0]  io_data = '0;
  logic        kbc_irq1 = 1'b0, kbc_irq12 = 1'b0, obf = 1'b0, aux_obf = 1'b0;
  logic        irq1_out, irq12_out, emu_irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  kbd_emul_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_wr(io_wr),
    .io_port(io_port), .io_data(io_data), .kbc_irq1(kbc_irq1),
    .kbc_irq12(kbc_irq12), .obf(obf), .aux_obf(aux_obf),
    .irq1_out(irq1_out), .irq12_out(irq12_out), .emu_irq(emu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 12'h100;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] exp);
    reg_addr = 12'h100;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // write presented before edge N, captured at N, acts at N+1
  task automatic io_write(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    io_port = p; io_data = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    rd_chk("R1 word", 32'h0);
    chk("R1 outs", {29'h0, irq1_out, irq12_out, emu_irq}, 32'h0);
  endtask

  task automatic t_fields;
    wr_reg(12'h100, 32'hFFFF_FFFF);
    // en,cpend,irqen,xen,a20 writable; bit1 from char pending with obf=0
    rd_chk("R2 R8 R11 all-ones", 32'h0000_011F);
    wr_reg(12'h100, 32'h0000_0000);
    rd_chk("R2 zero", 32'h0);
    wr_reg(12'h100, 32'h0000_0022);
    rd_chk("R2 ro bits", 32'h0);
  endtask

  task automatic t_offset;
    wr_reg(12'h104, 32'h0000_0001);
    rd_chk("R12 no write", 32'h0);
    reg_addr = 12'h104; #1;
    chk("R12 read other", reg_rdata, 32'h0);
    reg_addr = 12'h100;
  endtask

  task automatic t_edges;
    @(negedge clk); kbc_irq1 = 1'b1;
    @(negedge clk); #1;
    rd_chk("R3 not yet", 32'h0);
    @(negedge clk); #1;
    rd_chk("R3 irq1 set", 32'h0000_0040);
    wr_reg(12'h100, 32'h0000_0040);
    repeat (3) @(negedge clk);
    rd_chk("R3 R4 level no retrig", 32'h0);
    kbc_irq1 = 1'b0; kbc_irq12 = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R3 irq12 set", 32'h0000_0080);
    wr_reg(12'h100, 32'h0000_0000);
    rd_chk("R4 w0 holds", 32'h0000_0080);
    wr_reg(12'h100, 32'h0000_0040);
    rd_chk("R4 other bit holds", 32'h0000_0080);
    wr_reg(12'h100, 32'h0000_0080);
    rd_chk("R4 w1 clears", 32'h0);
    kbc_irq12 = 1'b0;
  endtask

  task automatic t_ext;
    @(negedge clk); kbc_irq12 = 1'b1;
    repeat (2) @(negedge clk); kbc_irq12 = 1'b0;
    #1; chk("R9 xen off", {31'h0, emu_irq}, 32'h0);
    wr_reg(12'h100, 32'h0000_0010);
    chk("R9 raised en=0", {31'h0, emu_irq}, 32'h1);
    rd_chk("R11 bit1", 32'h0000_0092);
    wr_reg(12'h100, 32'h0000_0090);
    chk("R9 dropped", {31'h0, emu_irq}, 32'h0);
    wr_reg(12'h100, 32'h0);
  endtask

  task automatic t_seq;
    io_write(16'h0064, 8'hD1);
    rd_chk("R6 ignored while off", 32'h0);
    wr_reg(12'h100, 32'h0000_0001);
    io_write(16'h0064, 8'hD1);
    rd_chk("R5 armed", 32'h0000_0021);
    io_write(16'h0060, 8'h02);
    io_write(16'h0064, 8'hD0);
    rd_chk("R5 disarmed", 32'h0000_0001);
    io_write(16'h0064, 8'hD1);
    wr_reg(12'h100, 32'h0);
    io_write(16'h0064, 8'h00);
    rd_chk("R6 held while off", 32'h0000_0020);
    io_write(16'h0060, 8'h02);
    chk("R6 no trap while off", {31'h0, emu_irq}, 32'h0);
  endtask

  task automatic t_a20(input logic lvl);
    logic [7:0] same, diff;
    same = lvl ? 8'h02 : 8'h00;
    diff = lvl ? 8'hFD : 8'hFF;
    wr_reg(12'h100, {23'h0, lvl, 8'h01});
    io_write(16'h0064, 8'hD1);
    io_write(16'h0060, same);
    chk("R10 match no trap", {31'h0, emu_irq}, 32'h0);
    io_write(16'h0060, diff);
    chk("R10 mismatch trap", {31'h0, emu_irq}, 32'h1);
    wr_reg(12'h100, {23'h0, lvl, 8'h01});
    chk("R10 reg write clears", {31'h0, emu_irq}, 32'h0);
    io_write(16'h0060, diff);
    chk("R10 trap again", {31'h0, emu_irq}, 32'h1);
    io_write(16'h0064, 8'h55);
    chk("R10 cmd write clears", {31'h0, emu_irq}, 32'h0);
    io_write(16'h0060, diff);
    chk("R10 disarmed no trap", {31'h0, emu_irq}, 32'h0);
    wr_reg(12'h100, 32'h0);
  endtask

  task automatic t_route;
    wr_reg(12'h100, 32'h0000_0008);
    obf = 1'b1; aux_obf = 1'b0; #1;
    chk("R7 irq1", {30'h0, irq12_out, irq1_out}, 32'h1);
    aux_obf = 1'b1; #1;
    chk("R7 irq12", {30'h0, irq12_out, irq1_out}, 32'h2);
    obf = 1'b0; #1;
    chk("R7 empty", {30'h0, irq12_out, irq1_out}, 32'h0);
    wr_reg(12'h100, 32'h0);
    obf = 1'b1; #1;
    chk("R7 disabled", {30'h0, irq12_out, irq1_out}, 32'h0);
    obf = 1'b0; aux_obf = 1'b0;
  endtask

  task automatic t_char;
    obf = 1'b1;
    wr_reg(12'h100, 32'h0000_0004);
    chk("R8 full no irq", {31'h0, emu_irq}, 32'h0);
    rd_chk("R11 bit1 low", 32'h0000_0004);
    obf = 1'b0; #1;
    chk("R8 empty irq", {31'h0, emu_irq}, 32'h1);
    rd_chk("R11 bit1 high", 32'h0000_0006);
    wr_reg(12'h100, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_offset();
    t_edges();
    t_ext();
    t_seq();
    t_a20(1'b0);
    t_a20(1'b1);
    t_route();
    t_char();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule